// File: doc/BRIEF.md
# Frame Overhead Bit Demultiplexer

This block receives a frame that is already aligned and descrambled, one bit per bit-clock enable, and sorts each bit by its position in the frame. Every position holds one of five kinds of bit: sync word, indicator, embedded operations channel (EOC), CRC, or Z-bit. Any other position carries payload. Only the indicator, EOC and Z-bit kinds are collected. Each of these has its own shift collector. When the last overhead bit of the frame arrives, all three collectors are copied together into holding registers that the host can read.

The holding registers are overwritten at every frame boundary. The host therefore has to read them and pulse an acknowledge within each frame. If the host does not, a sticky overrun flag records that data was lost. A frame-start pulse marks bit position 0. It also throws away any bits collected so far. Between frame-start pulses, the position counter wraps on its own at the frame length.

The position-to-kind table is a parameter. The widths of the three registers are derived from it. The values below are for the default 64-bit frame.

Top module: `ohd_demux`

## Requirements
- R1: After reset, `ind_reg`, `eoc_reg`, `z_reg`, `upd_stb` and `overrun` are all zero.
- R2: A bit is taken only on a clock where `bit_en` is high, and the position counter advances only on those clocks. `frame_start` together with `bit_en` marks the current bit as position 0. Default map: 0-6 sync, 7-10 indicator, 21-28 EOC, 41-46 CRC, 56-61 Z-bits, every other position payload.
- R3: `ind_reg` (4 bits) holds the indicator bits of the frame, with the earliest received bit in the MSB.
- R4: `eoc_reg` (8 bits) holds the EOC bits of the frame, with the earliest received bit in the MSB.
- R5: `z_reg` (6 bits) holds the Z-bits of the frame, with the earliest received bit in the MSB.
- R6: Sync, CRC and payload bits have no effect on any register.
- R7: All three holding registers load together on the edge that takes position 61, which is the last overhead bit. `upd_stb` is high for exactly the one clock in which the new values first appear.
- R8: The holding registers do not change on any clock where `upd_stb` is low.
- R9: A `frame_start` in the middle of a frame discards the bits collected so far and restarts at position 0. The aborted frame produces no update.
- R10: Without `frame_start`, the counter wraps from position 63 to position 0, and every full frame produces one update.
- R11: No update happens after reset until the first `frame_start` has been taken.
- R12: `overrun` is set when a load happens while the previous update is still unacknowledged. An update counts as acknowledged once a `host_ack` pulse occurs after it. A `host_ack` on the same clock as a load acknowledges the earlier update. Once set, `overrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable: one serial bit is taken on each clock where this is high |
| frame_start | input | 1 | Marks the current bit as position 0 of a frame |
| sdata | input | 1 | Serial frame data |
| host_ack | input | 1 | Host has read the holding registers |
| ind_reg | output | 4 | Indicator holding register |
| eoc_reg | output | 8 | EOC holding register |
| z_reg | output | 6 | Z-bit holding register |
| upd_stb | output | 1 | One-clock pulse when the holding registers take new values |
| overrun | output | 1 | Sticky: an update was overwritten before it was acknowledged |

## Verification
The case that is hardest to reach from the ports is a host acknowledge that lands on the exact clock of the next reload. The tie rule decides whether `overrun` rises in that case. The stimulus reaches it with a frame generator that can place `host_ack` on the bit at the last overhead position, after an earlier frame was left unacknowledged. The generator also cuts a frame short with a fresh frame-start and inserts idle `bit_en` clocks. This shows that an aborted frame, a gap, and a wrap without frame-start each land on the right load edge.

// File: rtl/ohd_pkg.sv
package ohd_pkg;

    localparam int MAX_BITS = 128;
    localparam int CAT_W    = 3;

    typedef enum logic [CAT_W-1:0] {
        CAT_PAY  = 3'd0,
        CAT_SYNC = 3'd1,
        CAT_IND  = 3'd2,
        CAT_EOC  = 3'd3,
        CAT_CRC  = 3'd4,
        CAT_Z    = 3'd5
    } cat_e;

    // one category code per bit position
    typedef logic [MAX_BITS-1:0][CAT_W-1:0] cat_map_t;

    // per-bit record handed from the position tracker to the collectors
    typedef struct packed {
        logic             adv;
        logic             restart;
        logic             load;
        logic [CAT_W-1:0] cat;
        logic             din;
    } slot_t;

    function automatic cat_map_t default_map();
        cat_map_t m;
        m = '0;
        for (int p = 0;  p < 7;  p++) m[p] = CAT_SYNC;
        for (int p = 7;  p < 11; p++) m[p] = CAT_IND;
        for (int p = 21; p < 29; p++) m[p] = CAT_EOC;
        for (int p = 41; p < 47; p++) m[p] = CAT_CRC;
        for (int p = 56; p < 62; p++) m[p] = CAT_Z;
        return m;
    endfunction

    function automatic int count_cat(cat_map_t m, int nbits, logic [CAT_W-1:0] c);
        int n;
        n = 0;
        for (int p = 0; p < MAX_BITS; p++)
            if (p < nbits && m[p] == c) n++;
        return n;
    endfunction

    function automatic int last_overhead(cat_map_t m, int nbits);
        int l;
        l = 0;
        for (int p = 0; p < MAX_BITS; p++)
            if (p < nbits && m[p] != CAT_PAY) l = p;
        return l;
    endfunction

endpackage

// File: rtl/ohd_bitpos.sv
module ohd_bitpos import ohd_pkg::*; #(
    parameter int       FRAME_BITS = 64,
    parameter cat_map_t CAT_MAP    = default_map(),
    parameter int       LAST_OH    = 61,
    localparam int      CNT_W      = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  logic  frame_start,
    input  logic  sdata,
    output slot_t slot
);

    localparam logic [CNT_W-1:0] WRAP_POS = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LOAD_POS = CNT_W'(LAST_OH);

    logic [CAT_W-1:0] map_r [FRAME_BITS];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic             locked_q;
    logic             fs;

    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_map
        assign map_r[i] = CAT_MAP[i];
    end

    always_comb begin
        fs           = bit_en & frame_start;
        pos          = fs ? '0 : cnt_q;
        slot.adv     = bit_en;
        slot.restart = fs;
        slot.cat     = map_r[pos];
        slot.din     = sdata;
        slot.load    = bit_en && (locked_q || fs) && (pos == LOAD_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else if (bit_en) begin
            cnt_q <= (pos == WRAP_POS) ? '0 : pos + 1'b1;
            if (fs) locked_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ohd_collect.sv
module ohd_collect import ohd_pkg::*; #(
    parameter int               W   = 4,
    parameter logic [CAT_W-1:0] CAT = CAT_IND
) (
    input  logic         clk,
    input  logic         rst,
    input  slot_t        slot,
    output logic [W-1:0] nxt
);

    logic [W-1:0] sh_q;
    logic [W-1:0] base;
    logic         hit;

    always_comb begin
        hit  = (slot.cat == CAT);
        base = slot.restart ? '0 : sh_q;
        nxt  = hit ? W'({base, slot.din}) : base;
    end

    always_ff @(posedge clk) begin
        if (rst)           sh_q <= '0;
        else if (slot.adv) sh_q <= nxt;
    end

endmodule

// File: rtl/ohd_hold.sv
module ohd_hold #(
    parameter int IW = 4,
    parameter int EW = 8,
    parameter int ZW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          ack,
    input  logic [IW-1:0] ind_n,
    input  logic [EW-1:0] eoc_n,
    input  logic [ZW-1:0] z_n,
    output logic [IW-1:0] ind_q,
    output logic [EW-1:0] eoc_q,
    output logic [ZW-1:0] z_q,
    output logic          upd,
    output logic          ovr
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ind_q  <= '0;
            eoc_q  <= '0;
            z_q    <= '0;
            upd    <= 1'b0;
            ovr    <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            upd <= load;
            if (load) begin
                ind_q  <= ind_n;
                eoc_q  <= eoc_n;
                z_q    <= z_n;
                pend_q <= 1'b1;
                if (pend_q && !ack) ovr <= 1'b1;
            end else if (ack) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ohd_demux.sv
module ohd_demux import ohd_pkg::*; #(
    parameter int       FRAME_BITS = 64,
    parameter cat_map_t CAT_MAP    = default_map(),
    localparam int      IND_W      = count_cat(CAT_MAP, FRAME_BITS, CAT_IND),
    localparam int      EOC_W      = count_cat(CAT_MAP, FRAME_BITS, CAT_EOC),
    localparam int      Z_W        = count_cat(CAT_MAP, FRAME_BITS, CAT_Z),
    localparam int      LAST_OH    = last_overhead(CAT_MAP, FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             frame_start,
    input  logic             sdata,
    input  logic             host_ack,
    output logic [IND_W-1:0] ind_reg,
    output logic [EOC_W-1:0] eoc_reg,
    output logic [Z_W-1:0]   z_reg,
    output logic             upd_stb,
    output logic             overrun
);

    localparam int               CW [3] = '{IND_W, EOC_W, Z_W};
    localparam logic [CAT_W-1:0] CC [3] = '{CAT_IND, CAT_EOC, CAT_Z};

    slot_t slot;

    ohd_bitpos #(
        .FRAME_BITS (FRAME_BITS),
        .CAT_MAP    (CAT_MAP),
        .LAST_OH    (LAST_OH)
    ) u_pos (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .sdata       (sdata),
        .slot        (slot)
    );

    for (genvar g = 0; g < 3; g++) begin : g_col
        logic [CW[g]-1:0] nxt_g;
        ohd_collect #(
            .W   (CW[g]),
            .CAT (CC[g])
        ) u_col (
            .clk  (clk),
            .rst  (rst),
            .slot (slot),
            .nxt  (nxt_g)
        );
    end

    ohd_hold #(
        .IW (IND_W),
        .EW (EOC_W),
        .ZW (Z_W)
    ) u_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (slot.load),
        .ack   (host_ack),
        .ind_n (g_col[0].nxt_g),
        .eoc_n (g_col[1].nxt_g),
        .z_n   (g_col[2].nxt_g),
        .ind_q (ind_reg),
        .eoc_q (eoc_reg),
        .z_q   (z_reg),
        .upd   (upd_stb),
        .ovr   (overrun)
    );

endmodule

// File: rtl/ohd_demux_chk.sv
module ohd_demux_chk #(
    parameter int IW = 4,
    parameter int EW = 8,
    parameter int ZW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_en,
    input logic          frame_start,
    input logic [IW-1:0] ind_reg,
    input logic [EW-1:0] eoc_reg,
    input logic [ZW-1:0] z_reg,
    input logic          upd_stb,
    input logic          overrun
);

    logic seen_fs_q;

    always_ff @(posedge clk) begin
        if (rst)                          seen_fs_q <= 1'b0;
        else if (bit_en && frame_start)   seen_fs_q <= 1'b1;
    end

    // R8: registers move only with the strobe
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |-> ($stable(ind_reg) && $stable(eoc_reg) && $stable(z_reg)));

    // R7: strobe follows a taken bit and lasts one clock
    a_r7_strobe_after_bit: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> $past(bit_en));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> !upd_stb);

    // R11: no update before the first frame start
    a_r11_no_load_unlocked: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> seen_fs_q);

    // R12: overrun is sticky and only rises with a reload
    a_r12_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r12_overrun_rise_on_load: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> upd_stb);

endmodule

bind ohd_demux ohd_demux_chk #(
    .IW (IND_W),
    .EW (EOC_W),
    .ZW (Z_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .frame_start (frame_start),
    .ind_reg     (ind_reg),
    .eoc_reg     (eoc_reg),
    .z_reg       (z_reg),
    .upd_stb     (upd_stb),
    .overrun     (overrun)
);

// File: tb/tb_ohd_demux.sv
`timescale 1ns/1ps
module tb_ohd_demux;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic frame_start = 1'b0;
    logic sdata = 1'b0;
    logic host_ack = 1'b0;
    logic [3:0] ind_reg;
    logic [7:0] eoc_reg;
    logic [5:0] z_reg;
    logic upd_stb;
    logic overrun;

    always #2 clk = ~clk;

    ohd_demux dut (.*);

    int total = 0;
    int bad = 0;
    int nupd = 0;

    // reference model state
    int       mcnt;
    bit       mlock, mpend, movr, mupd;
    bit [3:0] eind;
    bit [7:0] eeoc;
    bit [5:0] ez;
    bit       qi[$];
    bit       qe[$];
    bit       qz[$];
    bit [15:0] lf = 16'hACE1;

    function automatic bit lfsr_bit();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    // 0 payload, 1 sync, 2 indicator, 3 eoc, 4 crc, 5 z
    function automatic int cat_at(int p);
        if (p < 7) return 1;
        if (p < 11) return 2;
        if (p >= 21 && p < 29) return 3;
        if (p >= 41 && p < 47) return 4;
        if (p >= 56 && p < 62) return 5;
        return 0;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mcnt = 0; mlock = 0; mpend = 0; movr = 0; mupd = 0;
        eind = '0; eeoc = '0; ez = '0;
        qi.delete(); qe.delete(); qz.delete();
    endtask

    task automatic model_step(bit d, bit fs, bit en, bit ack);
        int pos;
        pos = fs ? 0 : mcnt;
        mupd = 0;
        if (en) begin
            if (fs) begin
                mlock = 1;
                qi.delete(); qe.delete(); qz.delete();
            end
            case (cat_at(pos))
                2: begin qi.push_back(d); if (qi.size() > 4) void'(qi.pop_front()); end
                3: begin qe.push_back(d); if (qe.size() > 8) void'(qe.pop_front()); end
                5: begin qz.push_back(d); if (qz.size() > 6) void'(qz.pop_front()); end
                default: ;
            endcase
            if (mlock && pos == 61) begin
                eind = '0; foreach (qi[i]) eind = {eind[2:0], qi[i]};
                eeoc = '0; foreach (qe[i]) eeoc = {eeoc[6:0], qe[i]};
                ez   = '0; foreach (qz[i]) ez   = {ez[4:0],   qz[i]};
                if (mpend && !ack) movr = 1;
                mpend = 1;
                mupd = 1;
            end else if (ack) begin
                mpend = 0;
            end
            mcnt = (pos == 63) ? 0 : pos + 1;
        end else if (ack) begin
            mpend = 0;
        end
    endtask

    task automatic step(bit d, bit fs, bit en, bit ack);
        @(negedge clk);
        sdata = d; frame_start = fs; bit_en = en; host_ack = ack;
        model_step(d, fs, en, ack);
        @(posedge clk);
        #1;
        if (upd_stb) nupd++;
        chk(ind_reg == eind, "R3 R8 indicator register", ind_reg, eind);
        chk(eoc_reg == eeoc, "R4 R8 eoc register", eoc_reg, eeoc);
        chk(z_reg == ez, "R5 R8 z register", z_reg, ez);
        chk(upd_stb == mupd, "R7 update strobe", upd_stb, mupd);
        chk(overrun == movr, "R12 overrun flag", overrun, movr);
    endtask

    // ackmode: 0 none, 1 ack after the frame, 2 ack on the load bit
    task automatic frame(bit use_fs, bit gaps, int ackmode, int nbits, bit keep_oh);
        for (int p = 0; p < nbits; p++) begin
            bit d;
            int c;
            d = lfsr_bit();
            c = cat_at(p);
            if (keep_oh && (c == 2 || c == 3 || c == 5)) d = p[0] ^ p[2];
            if (gaps && (p % 5 == 2)) step(1'b0, 1'b0, 1'b0, 1'b0);
            step(d, use_fs && p == 0, 1'b1, ackmode == 2 && p == 61);
        end
        if (ackmode == 1) step(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; bit_en = 0; frame_start = 0; host_ack = 0; sdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        chk(ind_reg == 0, "R1 indicator after reset", ind_reg, 0);
        chk(eoc_reg == 0, "R1 eoc after reset", eoc_reg, 0);
        chk(z_reg == 0, "R1 z after reset", z_reg, 0);
        chk(upd_stb == 0, "R1 strobe after reset", upd_stb, 0);
        chk(overrun == 0, "R1 overrun after reset", overrun, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0;
        bit [3:0] si;
        bit [7:0] se;
        bit [5:0] sz;

        do_reset();

        // R11: bits without any frame start give no update
        nupd = 0;
        for (int i = 0; i < 70; i++) step(lfsr_bit(), 1'b0, 1'b1, 1'b0);
        chk(nupd == 0, "R11 updates before first frame start", nupd, 0);

        // first locked frame
        n0 = nupd;
        frame(1, 0, 1, 64, 0);
        chk(nupd - n0 == 1, "R7 one update per frame", nupd - n0, 1);

        // R6: only sync, crc and payload bits differ between two frames
        frame(1, 0, 1, 64, 1);
        si = ind_reg; se = eoc_reg; sz = z_reg;
        frame(1, 0, 1, 64, 1);
        chk(ind_reg == si, "R6 indicator unaffected by other bits", ind_reg, si);
        chk(eoc_reg == se, "R6 eoc unaffected by other bits", eoc_reg, se);
        chk(z_reg == sz, "R6 z unaffected by other bits", z_reg, sz);

        // R2: idle bit_en clocks inside a frame
        n0 = nupd;
        frame(1, 1, 1, 64, 0);
        chk(nupd - n0 == 1, "R2 gaps do not advance position", nupd - n0, 1);

        // R10: free-running wrap with no frame start
        n0 = nupd;
        frame(0, 0, 1, 64, 0);
        frame(0, 0, 1, 64, 0);
        frame(0, 0, 1, 64, 0);
        chk(nupd - n0 == 3, "R10 wrap frames update", nupd - n0, 3);

        // R9: aborted frame then a full one
        n0 = nupd;
        frame(1, 0, 1, 30, 0);
        chk(nupd == n0, "R9 aborted frame gives no update", nupd, n0);
        frame(1, 0, 1, 64, 0);
        chk(nupd - n0 == 1, "R9 restarted frame updates", nupd - n0, 1);

        // R12: ack on the same clock as reload, then a missed ack
        frame(1, 0, 0, 64, 0);
        frame(1, 0, 2, 64, 0);
        chk(overrun == 0, "R12 ack with reload keeps overrun low", overrun, 0);
        frame(1, 0, 0, 64, 0);
        chk(overrun == 1, "R12 missed ack sets overrun", overrun, 1);
        frame(1, 0, 1, 64, 0);
        chk(overrun == 1, "R12 overrun sticky", overrun, 1);

        do_reset();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule